// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block decides when the processor's bus sequencer hands its bus to an outside master, and when it takes the bus back. The outside master raises a hold request and must not drive the bus until the acknowledge output goes high. The arbiter samples the request on each rising clock edge. If a bus cycle is under way, the grant waits for the rising edge that ends that cycle's T4 state. If the sequencer is idle, the grant happens on the sampling edge itself.

While the acknowledge is high, the sequencer is held in a stall and a float enable tri-states every processor bus driver. When the request is sampled low again, the acknowledge is kept through the rest of that clock-high phase and removed at the next falling edge. The stall clears at the same moment, so the sequencer can open a new T1 on the rising edge that follows.

An optional synchronizer in front of the request input is selected by a parameter. A second parameter chooses between the falling-edge release and a plain rising-edge release.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While reset is held with the hold request low, hlda, stall and float_en are all low.
- R2: A hold request sampled high on a rising edge while seq_busy is low raises hlda right after that same edge.
- R3: A hold request sampled high while seq_busy is high leaves hlda low on every rising edge where cyc_end is low. hlda rises right after the first rising edge that samples cyc_end high.
- R4: Whenever the sampled hold request is high and hlda is low, stall is high, so no new T1 can begin.
- R5: hlda stays high on every rising edge at which the hold request is still sampled high.
- R6: When the hold request is sampled low while hlda is high, hlda stays high until the following falling edge and is low after it.
- R7: After hlda falls, and while the hold request is low, stall is low before the next rising edge, so a new bus cycle may start on that edge.
- R8: float_en is high exactly when hlda is high, in both clock phases.
- R9: A request that drops before it is granted produces no hlda pulse, and stall returns low once the request is low and no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edges sample, falling edges release |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_req | input | 1 | Bus request from the outside master |
| seq_busy | input | 1 | High while the sequencer is inside a T1..T4 bus cycle |
| cyc_end | input | 1 | High during the final T4 clock of the current bus cycle |
| hlda | output | 1 | Hold acknowledge to the outside master |
| stall | output | 1 | Stops the sequencer from starting or continuing cycles |
| float_en | output | 1 | Tri-states the processor bus drivers |

## Verification
The bench sweeps the number of busy clocks before T4 ends against the length of the hold. A design that granted in the middle of a cycle would raise hlda on an edge where cyc_end was low. A design that granted one edge late would leave the master waiting an extra clock. Each release is checked in both clock phases. This catches a design that dropped hlda on the rising edge, and one that kept stall high into the next clock and so delayed the first T1. Requests withdrawn while pending are also covered, because a design that latched a stale request would hand over the bus to a master that no longer wants it.

// File: rtl/bhra_pkg.sv
package bhra_pkg;

   typedef enum logic [1:0] {
      ARB_FREE  = 2'd0,
      ARB_WAIT  = 2'd1,
      ARB_OWNED = 2'd2
   } arb_state_t;

   localparam int unsigned MAX_SYNC_STAGES = 4;

endpackage

// File: rtl/bhra_hold_sync.sv
module bhra_hold_sync #(
   parameter int unsigned STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_in,
   output logic req_out
);

   generate
      if (STAGES == 0) begin : g_direct
         assign req_out = req_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else if (STAGES == 1) begin
               chain_q <= req_in;
            end else begin
               chain_q <= {chain_q[STAGES-2:0], req_in};
            end
         end
         assign req_out = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bhra_grant_ctrl.sv
module bhra_grant_ctrl
   import bhra_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_s,
   input  logic seq_busy,
   input  logic cyc_end,
   output logic owned_p,
   output logic waiting
);

   arb_state_t state_q, state_d;
   logic       boundary;

   // A grant may only land where no bus cycle is open or the open one closes.
   assign boundary = cyc_end | ~seq_busy;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ARB_FREE: begin
            if (req_s) state_d = boundary ? ARB_OWNED : ARB_WAIT;
         end
         ARB_WAIT: begin
            if (!req_s)        state_d = ARB_FREE;
            else if (boundary) state_d = ARB_OWNED;
         end
         ARB_OWNED: begin
            if (!req_s) state_d = ARB_FREE;
         end
         default: state_d = ARB_FREE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_FREE;
      else        state_q <= state_d;
   end

   assign owned_p = (state_q == ARB_OWNED);
   assign waiting = (state_q == ARB_WAIT);

endmodule

// File: rtl/bhra_release_edge.sv
module bhra_release_edge #(
   parameter bit NEG_RELEASE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic owned_p,
   output logic ack
);

   generate
      if (NEG_RELEASE) begin : g_fall
         logic owned_n_q;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) owned_n_q <= 1'b0;
            else        owned_n_q <= owned_p;
         end
         // Rise follows the rising-edge state; fall waits for the low phase.
         assign ack = owned_p | owned_n_q;
      end else begin : g_rise
         assign ack = owned_p;
      end
   endgenerate

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          NEG_RELEASE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_req,
   input  logic seq_busy,
   input  logic cyc_end,
   output logic hlda,
   output logic stall,
   output logic float_en
);

   generate
      if (SYNC_STAGES > bhra_pkg::MAX_SYNC_STAGES) begin : g_bad_sync
         $error("bus_hold_arbiter: SYNC_STAGES out of range");
      end
   endgenerate

   logic hold_s;
   logic owned_p;
   logic waiting;
   logic ack;

   bhra_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (hold_req),
      .req_out (hold_s)
   );

   bhra_grant_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (hold_s),
      .seq_busy (seq_busy),
      .cyc_end  (cyc_end),
      .owned_p  (owned_p),
      .waiting  (waiting)
   );

   bhra_release_edge #(.NEG_RELEASE(NEG_RELEASE)) u_rel (
      .clk     (clk),
      .rst_n   (rst_n),
      .owned_p (owned_p),
      .ack     (ack)
   );

   assign hlda     = ack;
   assign float_en = ack;
   assign stall    = hold_s | waiting | ack;

endmodule

// File: rtl/bhra_checker.sv
module bhra_checker (
   input logic clk,
   input logic rst_n,
   input logic hold_s,
   input logic seq_busy,
   input logic cyc_end,
   input logic hlda,
   input logic stall
);

   a_r2_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && !seq_busy && !hlda) |=> hlda);

   a_r3_no_midcycle_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && seq_busy && !cyc_end && !hlda) |=> !hlda);

   a_r3_grant_at_t4: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && cyc_end && !hlda) |=> hlda);

   a_r4_request_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && !hlda) |-> stall);

   a_r5_keep_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_s && hlda) |=> hlda);

   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_s && hlda) |=> !hlda);

   a_r9_no_spurious_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_s && !hlda) |=> !hlda);

endmodule

bind bus_hold_arbiter bhra_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold_s   (hold_s),
   .seq_busy (seq_busy),
   .cyc_end  (cyc_end),
   .hlda     (hlda),
   .stall    (stall)
);

// File: tb/tb_bus_hold_arbiter.sv
module tb_bus_hold_arbiter;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_req = 1'b0;
   logic seq_busy = 1'b0;
   logic cyc_end = 1'b0;
   logic hlda, stall, float_en;

   int n_checks = 0;
   int n_fail = 0;

   // Reference state from the requirements
   bit m_own = 1'b0;
   bit m_wait = 1'b0;
   bit m_rel = 1'b0;

   bus_hold_arbiter dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_req (hold_req),
      .seq_busy (seq_busy),
      .cyc_end  (cyc_end),
      .hlda     (hlda),
      .stall    (stall),
      .float_en (float_en)
   );

   always #4 clk = ~clk;

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // One clock: low-phase checks, new inputs, then high-phase checks.
   task automatic cyc(input string tag, input bit h, input bit b, input bit e);
      bit exp_ack;
      @(negedge clk); #1;
      chk(tag, "hlda low phase (R6)", hlda, m_own);
      chk("R8", "float_en low phase", float_en, m_own);
      chk("R7", "stall low phase", stall, hold_req | m_wait | m_own);
      hold_req = h; seq_busy = b; cyc_end = e;
      #1;
      chk("R4", "stall before edge", stall, h | m_wait | m_own);
      @(posedge clk);
      m_rel = 1'b0;
      if (m_own) begin
         if (!h) begin m_own = 1'b0; m_rel = 1'b1; end
      end else if (h) begin
         if (e || !b) begin m_own = 1'b1; m_wait = 1'b0; end
         else m_wait = 1'b1;
      end else begin
         m_wait = 1'b0;
      end
      #1;
      exp_ack = m_own | m_rel;
      chk(tag, "hlda high phase", hlda, exp_ack);
      chk("R8", "float_en high phase", float_en, exp_ack);
      chk(tag, "stall high phase", stall, h | m_wait | exp_ack);
   endtask

   initial begin
      #800000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #20;
      chk("R1", "hlda in reset", hlda, 1'b0);
      chk("R1", "stall in reset", stall, 1'b0);
      chk("R1", "float_en in reset", float_en, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      cyc("R1", 0, 0, 0);

      // Idle grant, hold a few clocks, release
      cyc("R2", 1, 0, 0);
      for (int i = 0; i < 3; i++) cyc("R5", 1, 0, 0);
      cyc("R6", 0, 0, 0);
      cyc("R7", 0, 1, 0);

      // Request withdrawn while pending
      cyc("R9", 1, 1, 0);
      cyc("R9", 1, 1, 0);
      cyc("R9", 0, 1, 0);
      cyc("R9", 0, 1, 1);
      cyc("R9", 0, 0, 0);

      // Sweep: busy clocks before T4 end against hold length
      for (int w = 0; w < 6; w++) begin
         for (int hl = 1; hl < 5; hl++) begin
            for (int k = 0; k < w; k++) cyc("R3", 1, 1, 0);
            cyc("R3", 1, 1, 1);
            for (int k = 1; k < hl; k++) cyc("R5", 1, 0, 0);
            cyc("R6", 0, 0, 0);
            cyc("R7", 0, 1, 0);
            cyc("R7", 0, 1, 1);
         end
      end

      // Re-request right after release
      cyc("R2", 1, 0, 0);
      cyc("R6", 0, 0, 0);
      cyc("R2", 1, 0, 0);
      cyc("R6", 0, 0, 0);
      cyc("R7", 0, 0, 0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule